// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built around a down-counter that software keeps from expiring. Software restarts it by writing one fixed key byte to a dedicated reload address. All control passes through a small byte-wide register port: a reload address, a control byte with an enable bit and a reset-request bit, a rate code, and a 16-bit reload value split across two byte addresses. The running counter value can be read back through two more byte addresses.

Once enabled, the counter steps down by one on every 2^n-th pulse of an external 1 MHz tick strobe, where n is the rate code. When it reaches zero it stays there and raises a board reset request for a fixed number of clock cycles. The request fires once per expiry. When the board is the system controller, the same pulse also appears on a system reset request. The reset sequencer and the backplane drivers sit outside this block. All ports are plain control and status pins, so no valid/ready handshake applies: a write takes effect on the clock edge at which `wr_en_i` is high, and reads are combinational.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the reload value reads 0x03FF, the rate code reads 9, the control byte reads 0, the live counter reads 0x03FF and both reset requests are low.
- R2: Byte addresses are: 0 reload key (reads 0), 1 control (bit 0 enable, bit 1 reset-request enable), 2 rate code (bits 3:0), 3 and 4 reload value low and high byte, 5 and 6 live counter low and high byte (read only). Written fields read back unchanged.
- R3: Writing exactly 0xDB to address 0 loads the live counter from the reload value at that clock edge, whether or not the watchdog is enabled, and restarts the rate divider.
- R4: Writing any other byte to address 0 leaves the live counter unchanged.
- R5: A control write that sets the enable bit while it is clear loads the live counter from the reload value.
- R6: While the enable bit is clear the live counter holds its value despite ticks.
- R7: With rate code n, counted from a reload, the counter drops by one on each tick whose number is a multiple of 2^n, so after N ticks it reads max(0, V - floor(N / 2^n)).
- R8: The counter stops at zero and never wraps around.
- R9: In the clock cycle after the enabled counter reaches zero, with reset-request enable set, the board reset request goes high for exactly PULSE_CYC (default 8) cycles. It does not fire again until a reload.
- R10: The system reset request follows the board reset request while `sys_ctrl_i` is high, and stays low while it is low.
- R11: With reset-request enable clear, an expiry raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write byte address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read byte address |
| rd_data_o | output | 8 | Combinational read data |
| tick_i | input | 1 | 1 MHz tick strobe, one clock wide |
| sys_ctrl_i | input | 1 | Board acts as system controller |
| board_rst_o | output | 1 | Board reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The decrement rate is tried with random rate codes, reload values and tick counts below the expiry point. Each run is compared with max(0, V - N>>n), which separates a correct divider from one that is off by one tick or by one power of two. Directed sequences cover the other cases: a key reload in the middle of a divider period, which shows whether the divider restarts, and a near-miss key, which shows whether the key comparison is exact. Expiry is run with the system controller role on and off and with the request enable clear. Counting the pulse cycles over a window gives the pulse width, and a second window shows whether the pulse fires again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W  = 3;
  localparam int BYTE_W  = 8;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
  localparam logic [ADDR_W-1:0] A_VAL  = 3'd3;  // reload value base
  localparam int CTRL_EN  = 0;
  localparam int CTRL_REQ = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter int          RATE_W  = 4,
  parameter logic [7:0]  KEY     = 8'hDB,
  parameter logic [CNT_W-1:0] RST_VAL = 16'h03FF,
  parameter logic [RATE_W-1:0] RST_RATE = 4'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  reload_val,
  output logic [RATE_W-1:0] rate,
  output logic              en,
  output logic              req_en,
  output logic              reload
);
  localparam int NBYTES = CNT_W / BYTE_W;

  logic key_hit, en_rise;

  assign key_hit = wr_en && (wr_addr == A_KEY) && (wr_data == KEY);
  assign en_rise = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_EN] && !en;
  assign reload  = key_hit || en_rise;

  for (genvar b = 0; b < NBYTES; b++) begin : g_val
    localparam logic [ADDR_W-1:0] ADDR = A_VAL + ADDR_W'(b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reload_val[b*BYTE_W +: BYTE_W] <= RST_VAL[b*BYTE_W +: BYTE_W];
      else if (wr_en && wr_addr == ADDR)
        reload_val[b*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      req_en <= 1'b0;
      rate   <= RST_RATE;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        en     <= wr_data[CTRL_EN];
        req_en <= wr_data[CTRL_REQ];
      end
      if (wr_addr == A_RATE)
        rate <= wr_data[RATE_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_rate.sv
module wdt_rate #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              reload,
  input  logic [RATE_W-1:0] rate,
  output logic              step
);
  localparam int PRE_W = (1 << RATE_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'((PRE_W+1)'(1) << rate) - PRE_W'(1);
  assign step = tick && en && !reload && ((pre & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (reload)        pre <= '0;
    else if (tick && en)    pre <= pre + PRE_W'(1);
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W     = 16,
  parameter int PULSE_CYC = 8,
  parameter logic [CNT_W-1:0] RST_VAL = 16'h03FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             reload,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             pulse_on
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic          fired;
  logic [PW-1:0] pcnt;

  assign pulse_on = (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= RST_VAL;
    else if (reload)                   cnt <= reload_val;
    else if (step && cnt != '0)        cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired <= 1'b0;
      pcnt  <= '0;
    end else if (reload) begin
      fired <= 1'b0;
      pcnt  <= '0;
    end else if (en && cnt == '0 && !fired) begin
      fired <= 1'b1;
      pcnt  <= PW'(PULSE_CYC);
    end else if (pcnt != '0) begin
      pcnt  <= pcnt - PW'(1);
    end
  end

  // R8
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !reload) |=> cnt == '0);
  // R6
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> $stable(cnt));
  // R7
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));
  // R9
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> cnt == '0);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RATE_W    = 4,
  parameter int PULSE_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  input  logic        tick_i,
  input  logic        sys_ctrl_i,
  output logic        board_rst_o,
  output logic        sys_rst_o
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] A_LIVE = A_VAL + ADDR_W'(NBYTES);

  logic [CNT_W-1:0]  reload_val, cnt;
  logic [RATE_W-1:0] rate;
  logic              en, req_en, reload, step, pulse_on;

  wdt_regs #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .reload_val(reload_val), .rate(rate),
    .en(en), .req_en(req_en), .reload(reload));

  wdt_rate #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .en(en), .reload(reload),
    .rate(rate), .step(step));

  wdt_core #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(reload), .step(step),
    .reload_val(reload_val), .cnt(cnt), .pulse_on(pulse_on));

  assign board_rst_o = pulse_on && req_en;
  assign sys_rst_o   = board_rst_o && sys_ctrl_i;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL) begin
      rd_data_o[CTRL_EN]  = en;
      rd_data_o[CTRL_REQ] = req_en;
    end else if (rd_addr_i == A_RATE) begin
      rd_data_o[RATE_W-1:0] = rate;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (rd_addr_i == A_VAL + ADDR_W'(b))
          rd_data_o = reload_val[b*BYTE_W +: BYTE_W];
        if (rd_addr_i == A_LIVE + ADDR_W'(b))
          rd_data_o = cnt[b*BYTE_W +: BYTE_W];
      end
    end
  end

  // R10
  sys_follows_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> board_rst_o);
  // R3
  key_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_KEY && wr_data_i == 8'hDB) |=> cnt == $past(reload_val));
endmodule

// File: tb/wdt_keyed_top_tb.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, tick = 0, sys_ctrl = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       board_rst, sys_rst;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam int PULSE = 8;

  always #10 clk = ~clk;

  wdt_keyed_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_i(tick), .sys_ctrl_i(sys_ctrl), .board_rst_o(board_rst),
    .sys_rst_o(sys_rst));

  function automatic int exp_cnt(int v, int n, int res);
    int d = n >> res;
    return (d >= v) ? 0 : v - d;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd8(input logic [2:0] a, output int v);
    rd_addr = a; #1 v = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    int lo, hi;
    rd8(a, lo); rd8(a + 3'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic set_val(input int v);
    wr(3'd3, v[7:0]); wr(3'd4, v[15:8]);
  endtask

  task automatic count_req(input int cyc, output int nb, output int ns);
    nb = 0; ns = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      nb += board_rst; ns += sys_rst;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, nb, ns;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd16(3'd3, v); check("R1 reload value", v, 16'h03FF);
    rd8(3'd2, v);  check("R1 rate", v, 9);
    rd8(3'd1, v);  check("R1 control", v, 0);
    rd16(3'd5, v); check("R1 live", v, 16'h03FF);
    check("R1 requests", {board_rst, sys_rst}, 0);

    // R2 readback
    set_val(16'h1234); wr(3'd2, 8'hF2);
    rd16(3'd3, v); check("R2 value readback", v, 16'h1234);
    rd8(3'd2, v);  check("R2 rate readback", v, 2);
    rd8(3'd0, v);  check("R2 key reads zero", v, 0);

    // R5 enable reload
    set_val(10);
    wr(3'd1, 8'h01);
    rd16(3'd5, v); check("R5 enable reload", v, 10);
    rd8(3'd1, v);  check("R2 control readback", v, 1);

    // R7 directed, rate 2
    ticks(3); rd16(3'd5, v); check("R7 before 4th tick", v, 10);
    ticks(1); rd16(3'd5, v); check("R7 4th tick", v, 9);
    ticks(2);
    // R3 key reload mid period restarts divider
    wr(3'd0, 8'hDB);
    rd16(3'd5, v); check("R3 key reload", v, 10);
    ticks(3); rd16(3'd5, v); check("R3 divider restart", v, 10);
    ticks(1); rd16(3'd5, v); check("R3 divider restart step", v, 9);
    // R4 near-miss keys
    wr(3'd0, 8'hDA); rd16(3'd5, v); check("R4 key 0xDA", v, 9);
    wr(3'd0, 8'h5B); rd16(3'd5, v); check("R4 key 0x5B", v, 9);

    // R6 disabled hold, R3 key works while disabled
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hDB);
    rd16(3'd5, v); check("R3 key while disabled", v, 10);
    ticks(9); rd16(3'd5, v); check("R6 hold while disabled", v, 10);

    // R9/R10 timeout, system controller
    sys_ctrl = 1;
    set_val(3); wr(3'd2, 8'h00);
    wr(3'd1, 8'h03);
    ticks(3);
    rd16(3'd5, v); check("R8 reached zero", v, 0);
    count_req(20, nb, ns);
    check("R9 pulse width", nb, PULSE);
    check("R10 sys pulse", ns, PULSE);
    ticks(5); count_req(20, nb, ns);
    check("R9 no repeat", nb, 0);
    rd16(3'd5, v); check("R8 stays zero", v, 0);

    // R10 not system controller
    sys_ctrl = 0;
    wr(3'd0, 8'hDB); ticks(3);
    count_req(20, nb, ns);
    check("R9 pulse after reload", nb, PULSE);
    check("R10 no sys when not controller", ns, 0);

    // R11 request disabled
    wr(3'd1, 8'h01);
    wr(3'd0, 8'hDB); ticks(3);
    rd16(3'd5, v); check("R8 expiry without request", v, 0);
    count_req(20, nb, ns);
    check("R11 no board request", nb, 0);

    // R7 random rates and counts
    for (int it = 0; it < 8; it++) begin
      int res = $urandom % 4;
      int cv  = 1 + ($urandom % 30);
      int nt  = $urandom % (cv << res);
      wr(3'd1, 8'h00);
      set_val(cv); wr(3'd2, 8'(res));
      wr(3'd1, 8'h01);
      ticks(nt);
      rd16(3'd5, v);
      check("R7 random rate", v, exp_cnt(cv, nt, res));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule